// File: doc/BRIEF.md
# Active Priority Tracker with Binary Point Grouping

This block records which preemption levels are currently in service on one virtual CPU interface of an interrupt controller, and derives the running priority from that record. It holds one bitmap for Group 0 and one for Group 1. Each bitmap is split into 32-bit words. When an interrupt is acknowledged, the caller raises `act_valid` with the interrupt's 8-bit priority and its group. The block applies that group's binary point to remove the subpriority bits. It then scales the result down by the minimum binary point and sets the matching bit in the bitmap of that group.

The running priority `run_pri` is combinational from the registered bitmaps. It is built from the lowest set bit found in the two groups' bitmaps merged together, and it reads 0xFF when nothing is active. Software-side end-of-interrupt logic clears individual bits through a clear port. It can also empty a whole group through a flush port. Any word can be read back combinationally.

The activate, clear and flush inputs are plain one-cycle strobes. Each is consumed on the rising clock edge where it is high. There is no back-pressure: the block takes a request every cycle, so no ready signal exists. `rd_data` and `run_pri` follow their inputs in the same cycle.

Top module: `apt_tracker`

## Requirements
- R1: While `rst_n` is low and after reset, every bitmap word reads zero and `run_pri` is 0xFF.
- R2: The number of preemption bits is `cfg_prebits_m1` + 1. The minimum binary point is 8 minus that count. The number of words in use per group is 2^(bits − 5) when the count is 5 or more and 1 otherwise, capped at `NUM_WORDS` (4).
- R3: `act_grp` = 0 selects Group 0, whose grouping shift is `bp_g0` + 1. `act_grp` = 1 selects Group 1, whose grouping shift is `bp_g1`. The preemption level is `act_pri` AND (0xFF shifted left by the grouping shift). A shift of 8 gives level 0.
- R4: On `act_valid`, bit index = level >> minimum binary point. Bit (index mod 32) of word (index / 32) is set in the requesting group's bitmap at the next edge. No other bit of either bitmap changes.
- R5: An activation whose word (index / 32) is not below the number of words in use leaves both bitmaps unchanged.
- R6: `run_pri` is formed from the words in use only, taking the lowest word index w whose Group 0 and Group 1 words ORed together are nonzero. With b the lowest set bit of that OR, `run_pri` = ((32·w + b) << minimum binary point) truncated to 8 bits. If every word in use is zero, `run_pri` is 0xFF.
- R7: `clr_valid` clears bit `clr_pos`[4:0] of word `clr_pos`[6:5] in the bitmap selected by `clr_grp` (0 = Group 0).
- R8: `flush_valid` zeroes every word of the bitmap selected by `flush_grp` (0 = Group 0).
- R9: When an activation and a clear or flush hit the same group's bitmap in one cycle, the clear or flush is applied first. The activated bit is set afterwards.
- R10: `rd_data` shows word `rd_word` of the bitmap chosen by `rd_grp` (0 = Group 0) in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_prebits_m1 | input | 3 | Preemption bit count minus one |
| bp_g0 | input | 3 | Group 0 binary point |
| bp_g1 | input | 3 | Group 1 binary point |
| act_valid | input | 1 | Activate strobe |
| act_pri | input | 8 | Priority of the activated interrupt |
| act_grp | input | 1 | Group of the activated interrupt |
| clr_valid | input | 1 | Single-bit clear strobe |
| clr_grp | input | 1 | Group for the clear |
| clr_pos | input | 7 | Bit position (word, bit) to clear |
| flush_valid | input | 1 | Whole-group clear strobe |
| flush_grp | input | 1 | Group to flush |
| rd_grp | input | 1 | Read-back group select |
| rd_word | input | 2 | Read-back word select |
| rd_data | output | 32 | Selected bitmap word |
| run_pri | output | 8 | Running priority, 0xFF when idle |

## Verification
A wrong bit in either bitmap shows up in `rd_data` for its word in the cycle after the faulty edge. If that bit is below the lowest legitimately active level, it also pulls `run_pri` down at once. A wrong grouping shift or a wrong scale factor moves the bit to another position, which the read-back shows one edge after the activation. A wrong ordering of clear and set inside a cycle shows as a missing bit on the next read.

// File: rtl/apt_pkg.sv
package apt_pkg;

  // Words in use per group for a given preemption-bit code (R2)
  function automatic int words_in_use(int prebits_m1, int word_log, int max_words);
    int prebits;
    int w;
    prebits = prebits_m1 + 1;
    if (prebits <= word_log) w = 1;
    else w = 1 << (prebits - word_log);
    if (w > max_words) w = max_words;
    return w;
  endfunction

  // Minimum binary point: priority width minus preemption bits (R2)
  function automatic int min_bp(int prebits_m1, int pri_w);
    return pri_w - 1 - prebits_m1;
  endfunction

endpackage

// File: rtl/apt_level_map.sv
module apt_level_map #(
  parameter int PRI_W  = 8,
  parameter int BP_W   = 3,
  parameter int SH_W   = 4,
  parameter int POS_W  = 7,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic [PRI_W-1:0] pri,
  input  logic             grp,
  input  logic [BP_W-1:0]  bp0,
  input  logic [BP_W-1:0]  bp1,
  input  logic [SH_W-1:0]  minbp,
  input  logic [CNT_W-1:0] nwords,
  output logic [POS_W-1:0] pos,
  output logic             pos_ok
);
  localparam int WORD_LOG = $clog2(WORD_W);

  logic [SH_W-1:0]  shamt;
  logic [PRI_W-1:0] mask;
  logic [PRI_W-1:0] level;
  logic [PRI_W-1:0] idx;
  logic [PRI_W-1:0] word_sel;

  always_comb begin
    // R3: group 0 shifts one further than its binary point
    shamt    = grp ? SH_W'(bp1) : SH_W'(bp0) + SH_W'(1);
    mask     = {PRI_W{1'b1}} << shamt;
    level    = pri & mask;
    idx      = level >> minbp;
    word_sel = idx >> WORD_LOG;
    pos_ok   = (int'(word_sel) < int'(nwords));
    pos      = POS_W'(idx);
  end
endmodule

// File: rtl/apt_bitmap.sv
module apt_bitmap #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int POS_W     = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_en,
  input  logic [POS_W-1:0]              set_pos,
  input  logic                          clr_en,
  input  logic [POS_W-1:0]              clr_pos,
  input  logic                          flush,
  output logic [NUM_WORDS*WORD_W-1:0]   map_q
);
  localparam int WORD_LOG = $clog2(WORD_W);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] set_m;
    logic [WORD_W-1:0] clr_m;

    always_comb begin
      set_m = '0;
      clr_m = '0;
      if (set_en && (int'(set_pos >> WORD_LOG) == w))
        set_m = WORD_W'(1) << set_pos[WORD_LOG-1:0];
      if (clr_en && (int'(clr_pos >> WORD_LOG) == w))
        clr_m = WORD_W'(1) << clr_pos[WORD_LOG-1:0];
    end

    // R9: clear and flush act before the set of the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q <= '0;
      else if (flush)  word_q <= set_m;
      else             word_q <= (word_q & ~clr_m) | set_m;
    end

    assign map_q[w*WORD_W +: WORD_W] = word_q;
  end

  // R4
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> map_q[$past(set_pos)]);

  // R4
  no_stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> ((map_q & ~$past(map_q)) == '0));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !set_en) |=> (map_q == '0));

  // R7
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !flush && !(set_en && set_pos == clr_pos)) |=> !map_q[$past(clr_pos)]);
endmodule

// File: rtl/apt_prio_scan.sv
module apt_prio_scan #(
  parameter int PRI_W     = 8,
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int POS_W     = 7,
  parameter int SH_W      = 4,
  parameter int CNT_W     = 3
) (
  input  logic [NUM_WORDS*WORD_W-1:0] map0,
  input  logic [NUM_WORDS*WORD_W-1:0] map1,
  input  logic [SH_W-1:0]             minbp,
  input  logic [CNT_W-1:0]            nwords,
  output logic [PRI_W-1:0]            run_pri
);
  localparam int WORD_LOG = $clog2(WORD_W);

  function automatic logic [WORD_LOG-1:0] lowest_bit(logic [WORD_W-1:0] v);
    logic [WORD_LOG-1:0] r;
    r = '0;
    for (int b = WORD_W - 1; b >= 0; b--)
      if (v[b]) r = WORD_LOG'(b);
    return r;
  endfunction

  logic                     found;
  logic [POS_W-1:0]         lvl;
  logic [WORD_W-1:0]        merged;
  logic [POS_W+PRI_W-1:0]   scaled;

  // R6: descending walk so the lowest nonzero word is the last to win
  always_comb begin
    found  = 1'b0;
    lvl    = '0;
    merged = '0;
    for (int i = NUM_WORDS - 1; i >= 0; i--) begin
      merged = map0[i*WORD_W +: WORD_W] | map1[i*WORD_W +: WORD_W];
      if ((i < int'(nwords)) && (merged != '0)) begin
        found = 1'b1;
        lvl   = POS_W'(i * WORD_W) + POS_W'(lowest_bit(merged));
      end
    end
    scaled  = (POS_W+PRI_W)'(lvl) << minbp;
    run_pri = found ? PRI_W'(scaled) : {PRI_W{1'b1}};
  end
endmodule

// File: rtl/apt_tracker.sv
module apt_tracker
  import apt_pkg::*;
#(
  parameter int PRI_W     = 8,
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int CFG_W     = 3,
  parameter int BP_W      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   cfg_prebits_m1,
  input  logic [BP_W-1:0]    bp_g0,
  input  logic [BP_W-1:0]    bp_g1,
  input  logic               act_valid,
  input  logic [PRI_W-1:0]   act_pri,
  input  logic               act_grp,
  input  logic               clr_valid,
  input  logic               clr_grp,
  input  logic [$clog2(NUM_WORDS*WORD_W)-1:0] clr_pos,
  input  logic               flush_valid,
  input  logic               flush_grp,
  input  logic               rd_grp,
  input  logic [((NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1)-1:0] rd_word,
  output logic [WORD_W-1:0]  rd_data,
  output logic [PRI_W-1:0]   run_pri
);
  localparam int MAP_W    = NUM_WORDS * WORD_W;
  localparam int POS_W    = $clog2(MAP_W);
  localparam int WORD_LOG = $clog2(WORD_W);
  localparam int SH_W     = $clog2(PRI_W) + 1;
  localparam int CNT_W    = $clog2(NUM_WORDS + 1);

  logic [SH_W-1:0]  minbp;
  logic [CNT_W-1:0] nwords;
  logic [POS_W-1:0] act_pos;
  logic             act_ok;
  logic [MAP_W-1:0] map0, map1;
  logic             set0, set1;

  // R2: configuration-derived scale and span
  always_comb begin
    minbp  = SH_W'(min_bp(int'(cfg_prebits_m1), PRI_W));
    nwords = CNT_W'(words_in_use(int'(cfg_prebits_m1), WORD_LOG, NUM_WORDS));
  end

  apt_level_map #(
    .PRI_W(PRI_W), .BP_W(BP_W), .SH_W(SH_W), .POS_W(POS_W),
    .WORD_W(WORD_W), .CNT_W(CNT_W)
  ) u_map (
    .pri(act_pri), .grp(act_grp), .bp0(bp_g0), .bp1(bp_g1),
    .minbp(minbp), .nwords(nwords), .pos(act_pos), .pos_ok(act_ok)
  );

  assign set0 = act_valid && act_ok && !act_grp;
  assign set1 = act_valid && act_ok &&  act_grp;

  apt_bitmap #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .POS_W(POS_W)) u_bm0 (
    .clk(clk), .rst_n(rst_n),
    .set_en(set0), .set_pos(act_pos),
    .clr_en(clr_valid && !clr_grp), .clr_pos(clr_pos),
    .flush(flush_valid && !flush_grp),
    .map_q(map0)
  );

  apt_bitmap #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .POS_W(POS_W)) u_bm1 (
    .clk(clk), .rst_n(rst_n),
    .set_en(set1), .set_pos(act_pos),
    .clr_en(clr_valid && clr_grp), .clr_pos(clr_pos),
    .flush(flush_valid && flush_grp),
    .map_q(map1)
  );

  apt_prio_scan #(
    .PRI_W(PRI_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS),
    .POS_W(POS_W), .SH_W(SH_W), .CNT_W(CNT_W)
  ) u_scan (
    .map0(map0), .map1(map1), .minbp(minbp), .nwords(nwords), .run_pri(run_pri)
  );

  // R10
  assign rd_data = rd_grp ? map1[rd_word*WORD_W +: WORD_W]
                          : map0[rd_word*WORD_W +: WORD_W];

  // R6
  idle_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((map0 == '0) && (map1 == '0)) |-> (run_pri == {PRI_W{1'b1}}));

  // R5
  drop_out_of_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_ok && !clr_valid && !flush_valid)
      |=> ((map0 == $past(map0)) && (map1 == $past(map1))));

  // R1
  reset_clean_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> ((map0 == '0) && (map1 == '0)));
endmodule

// File: tb/apt_tracker_tb.sv
module apt_tracker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_prebits_m1 = 3'd4;
  logic [2:0]  bp_g0 = 3'd0, bp_g1 = 3'd0;
  logic        act_valid = 1'b0, act_grp = 1'b0;
  logic [7:0]  act_pri = 8'd0;
  logic        clr_valid = 1'b0, clr_grp = 1'b0;
  logic [6:0]  clr_pos = 7'd0;
  logic        flush_valid = 1'b0, flush_grp = 1'b0;
  logic        rd_grp = 1'b0;
  logic [1:0]  rd_word = 2'd0;
  logic [31:0] rd_data;
  logic [7:0]  run_pri;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string       req;
    logic [7:0]  run;
    logic [31:0] rd;
  } exp_t;
  exp_t q[$];

  logic [31:0] m0 [4];
  logic [31:0] m1 [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  apt_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_prebits_m1(cfg_prebits_m1),
    .bp_g0(bp_g0), .bp_g1(bp_g1),
    .act_valid(act_valid), .act_pri(act_pri), .act_grp(act_grp),
    .clr_valid(clr_valid), .clr_grp(clr_grp), .clr_pos(clr_pos),
    .flush_valid(flush_valid), .flush_grp(flush_grp),
    .rd_grp(rd_grp), .rd_word(rd_word), .rd_data(rd_data), .run_pri(run_pri)
  );

  function automatic int f_words(int code);
    int n;
    n = (code + 1 <= 5) ? 1 : (1 << (code + 1 - 5));
    return (n > 4) ? 4 : n;
  endfunction

  function automatic int f_minbp(int code);
    return 8 - (code + 1);
  endfunction

  function automatic int f_idx(int pri, bit g, int b0, int b1, int code);
    int sh;
    int lvl;
    sh  = g ? b1 : b0 + 1;
    lvl = (pri >> sh) << sh;
    return lvl >> f_minbp(code);
  endfunction

  function automatic logic [7:0] f_run(int code);
    logic [31:0] m;
    for (int w = 0; w < f_words(code); w++) begin
      m = m0[w] | m1[w];
      if (m != 0)
        for (int b = 0; b < 32; b++)
          if (m[b]) return 8'(((w * 32 + b) << f_minbp(code)) & 255);
    end
    return 8'hFF;
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // driver: one cycle of stimulus, model update, expected item pushed
  task automatic step(string req, int code, int b0, int b1,
                      bit a, int pri, bit g,
                      bit c, bit cg, int cp,
                      bit f, bit fg, bit rg, int rw);
    int idx;
    @(negedge clk);
    #2;
    cfg_prebits_m1 = 3'(code); bp_g0 = 3'(b0); bp_g1 = 3'(b1);
    act_valid = a; act_pri = 8'(pri); act_grp = g;
    clr_valid = c; clr_grp = cg; clr_pos = 7'(cp);
    flush_valid = f; flush_grp = fg;
    rd_grp = rg; rd_word = 2'(rw);
    if (f) for (int w = 0; w < 4; w++) if (fg) m1[w] = 0; else m0[w] = 0;
    if (c) begin
      if (cg) m1[cp / 32][cp % 32] = 1'b0;
      else    m0[cp / 32][cp % 32] = 1'b0;
    end
    if (a) begin
      idx = f_idx(pri, g, b0, b1, code);
      if (idx / 32 < f_words(code)) begin
        if (g) m1[idx / 32][idx % 32] = 1'b1;
        else   m0[idx / 32][idx % 32] = 1'b1;
      end
    end
    @(posedge clk);
    #1;
    act_valid = 1'b0; clr_valid = 1'b0; flush_valid = 1'b0;
    q.push_back('{req: req, run: f_run(code), rd: rg ? m1[rw] : m0[rw]});
  endtask

  // monitor: compare each expected item at the following falling edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        e = q.pop_front();
        chk(e.req, "run_pri", 32'(run_pri), 32'(e.run));
        chk(e.req, "rd_data", rd_data, e.rd);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < 4; w++) begin m0[w] = 0; m1[w] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "run_pri in reset", 32'(run_pri), 32'hFF);
    chk("R1", "rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "run_pri after reset", 32'(run_pri), 32'hFF);

    // R4 R6: group 1, shift 0, 5 bits -> idx 9, run 0x48
    step("R4", 4, 0, 0, 1, 8'h48, 1, 0, 0, 0, 0, 0, 1, 0);
    // R3 R4: group 0 shift bp+1 -> 0x30 idx 6
    step("R3", 4, 0, 0, 1, 8'h30, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3: group 1 bp 3 drops subpriority 0x5F -> 0x58 idx 11
    step("R3", 4, 0, 3, 1, 8'h5F, 1, 0, 0, 0, 0, 0, 1, 0);
    // R3 R6: group 0 bp 2 -> 0x17 -> 0x10 idx 2, new lowest
    step("R6", 4, 2, 3, 1, 8'h17, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7: clear group 0 bit 2
    step("R7", 4, 2, 3, 0, 0, 0, 1, 0, 2, 0, 0, 0, 0);
    // R8: flush group 0, group 1 untouched
    step("R8", 4, 2, 3, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step("R10", 4, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R2: 7 bits -> 4 words, min bp 1, same bits now scale by 2
    step("R2", 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R4 R10: top level in word 3
    step("R4", 6, 0, 0, 1, 8'hFE, 0, 0, 0, 0, 0, 0, 0, 3);
    step("R6", 6, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 3);
    // R2 R6: fewer words in use hides word 3 from the scan
    step("R6", 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
    // R3: group 0 bp 7 -> shift 8 -> level 0
    step("R3", 6, 7, 0, 1, 8'hE3, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5: 8 bits, word 6 beyond the four words -> dropped
    step("R5", 7, 0, 0, 1, 8'hC0, 1, 0, 0, 0, 0, 0, 1, 2);
    step("R5", 7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
    // R9: set and clear of the same bit in one cycle -> set survives
    step("R9", 6, 0, 0, 1, 8'h12, 1, 1, 1, 9, 0, 0, 1, 0);
    // R9: set with flush of same group -> only the new bit remains
    step("R9", 6, 0, 0, 1, 8'h40, 1, 0, 0, 0, 1, 1, 1, 1);
    // R2 R6: 2 bits -> min bp 6, 0xC0 -> idx 3 -> run 0xC0
    step("R2", 1, 0, 0, 1, 8'hC0, 1, 0, 0, 0, 1, 0, 1, 0);
    step("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule